// File: doc/BRIEF.md
# Sparse-Space PCI Address Translator

This block sits between a CPU-side port and a PCI transaction engine. A CPU access to sparse space encodes a PCI address, a transfer size and a byte offset together in one CPU address. The PCI address is shifted up by five bit positions. The size sits in bits 4:3 and the byte offset in bits 6:5. The block decodes these fields and issues one PCI transaction. That transaction carries a longword-aligned address, active-low byte enables and write data on the correct byte lanes. When the transaction completes, the block returns the read data taken from the same lanes, right-aligned.

Only the low 27 bits of the PCI address come from the CPU address. The three top PCI address bits come from a high-address-extension register, which is written through its own CSR port. A quadword request is split into two longword transactions. A word access that would cross a longword boundary is refused with an error, and it issues nothing on the PCI side.

Top module: `sparse_xlate`

## Requirements
- R1: The issued PCI address is {ext[2:0], 2'b00, cpu_addr[31:7], 2'b00}. Here ext is the extension register, so PCI bits 1:0 are always zero and bits 28:27 are zero.
- R2: The size code cpu_addr[4:3] is decoded as 00 = byte, 01 = word, 11 = longword. The offset off = cpu_addr[6:5]. pci_be_n is ~(4'b0001<<off) for a byte, ~(4'b0011<<off) for a word and 4'b0000 for a longword or quadword.
- R3: On writes, pci_wdata is cpu_wdata[31:0] shifted left by 8*off for a byte or word. For a longword it is cpu_wdata[31:0] unshifted.
- R4: On a byte or word read, cpu_rdata is pci_rdata shifted right by 8*off and masked to 8 or 16 bits, zero-extended. On a longword read it is pci_rdata zero-extended.
- R5: With cpu_quad high, two longword transactions are issued. The second is at a PCI address 4 above the first, and the 27-bit low part wraps. Writes send cpu_wdata[31:0] first and then [63:32]. Reads return {second, first}.
- R6: When cpu_quad is low, a word with off = 3 is illegal, and so is size code 10. Such a request raises cpu_done and cpu_err together one cycle after acceptance, and pci_valid never rises for it.
- R7: A csr_we write loads the extension register. It applies to the next request accepted after it and leaves a transaction already issued unchanged.
- R8: pci_valid and all pci_* request fields hold steady until a cycle with pci_done. cpu_done is a one-cycle pulse in the cycle after the final pci_done. cpu_busy is high from acceptance until cpu_done, and cpu_valid is ignored while busy.
- R9: After reset, pci_valid, cpu_done, cpu_err and cpu_busy are low and the extension register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_valid | input | 1 | Request strobe, taken when idle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_quad | input | 1 | Quadword request |
| cpu_addr | input | 29 | Sparse CPU address bits 31:3 |
| cpu_wdata | input | 64 | Write data |
| cpu_busy | output | 1 | Request in progress |
| cpu_done | output | 1 | Completion pulse |
| cpu_err | output | 1 | Illegal access, valid with cpu_done |
| cpu_rdata | output | 64 | Read data, valid with cpu_done |
| csr_we | input | 1 | Extension register write strobe |
| csr_wdata | input | 3 | Extension register value |
| pci_valid | output | 1 | PCI transaction request |
| pci_write | output | 1 | PCI transaction direction |
| pci_addr | output | 32 | PCI address |
| pci_be_n | output | 4 | Active-low byte enables |
| pci_wdata | output | 32 | PCI write data |
| pci_done | input | 1 | PCI transaction complete |
| pci_rdata | input | 32 | PCI read data, valid with pci_done |

## Verification
A request sampled at a clock edge shows on the pci_* outputs right after that edge, or shows as cpu_done with cpu_err when illegal. The bench drives inputs at the falling edge and checks the request fields at the following falling edge. The result is due one edge after the final pci_done. For a quadword, the second half replaces the first on the PCI outputs one edge after the first pci_done. Each check samples at the falling edge after the edge on which the relevant register loads.

// File: rtl/sparse_xlate.sv
module sparse_xlate #(
  parameter int PCI_AW = 32,
  parameter int EXT_W  = 3,
  parameter int LOW_W  = 27
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_valid,
  input  logic                 cpu_write,
  input  logic                 cpu_quad,
  input  logic [LOW_W+4:3]     cpu_addr,
  input  logic [63:0]          cpu_wdata,
  output logic                 cpu_busy,
  output logic                 cpu_done,
  output logic                 cpu_err,
  output logic [63:0]          cpu_rdata,
  input  logic                 csr_we,
  input  logic [EXT_W-1:0]     csr_wdata,
  output logic                 pci_valid,
  output logic                 pci_write,
  output logic [PCI_AW-1:0]    pci_addr,
  output logic [3:0]           pci_be_n,
  output logic [31:0]          pci_wdata,
  input  logic                 pci_done,
  input  logic [31:0]          pci_rdata
);
  localparam int CPU_AW = LOW_W + 5;
  localparam int GAP_W  = PCI_AW - EXT_W - LOW_W;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_RSP, S_ERR} st_t;
  st_t st;

  logic [CPU_AW-1:3] a_q;
  logic              wr_q, quad_q, half_q;
  logic [63:0]       wd_q, rd_q;
  logic [EXT_W-1:0]  ext_q, ext_snap;

  wire [1:0]  len   = a_q[4:3];
  wire [1:0]  off   = a_q[6:5];
  wire [4:0]  sh    = {off, 3'b000};
  wire        bad_in = !cpu_quad && (cpu_addr[4:3] == 2'b10 ||
                        (cpu_addr[4:3] == 2'b01 && cpu_addr[6:5] == 2'b11));
  wire [LOW_W-1:0] low_addr = LOW_W'({a_q[CPU_AW-1:7], 2'b00}) + (half_q ? LOW_W'(4) : LOW_W'(0));
  wire [31:0] rd_sh = pci_rdata >> sh;
  wire        full  = quad_q || len == 2'b11;

  assign cpu_busy  = st != S_IDLE;
  assign cpu_done  = st == S_RSP || st == S_ERR;
  assign cpu_err   = st == S_ERR;
  assign cpu_rdata = rd_q;
  assign pci_valid = st == S_ACT;
  assign pci_write = wr_q;
  assign pci_addr  = {ext_snap, {GAP_W{1'b0}}, low_addr};
  assign pci_be_n  = full ? 4'b0000 : (len == 2'b00 ? ~(4'b0001 << off) : ~(4'b0011 << off));
  assign pci_wdata = quad_q ? (half_q ? wd_q[63:32] : wd_q[31:0]) :
                     (len == 2'b11 ? wd_q[31:0] : wd_q[31:0] << sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= '0;
    else if (csr_we) ext_q <= csr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; a_q <= '0; wr_q <= 1'b0; quad_q <= 1'b0; half_q <= 1'b0;
      wd_q <= '0; rd_q <= '0; ext_snap <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_valid) begin
          a_q <= cpu_addr; wr_q <= cpu_write; quad_q <= cpu_quad;
          wd_q <= cpu_wdata; ext_snap <= ext_q; half_q <= 1'b0;
          st <= bad_in ? S_ERR : S_ACT;
        end
        S_ACT: if (pci_done) begin
          if (quad_q) begin
            if (half_q) rd_q[63:32] <= pci_rdata;
            else        rd_q[31:0]  <= pci_rdata;
            half_q <= 1'b1;
            if (half_q) st <= S_RSP;
          end else begin
            case (len)
              2'b00:   rd_q <= {56'b0, rd_sh[7:0]};
              2'b01:   rd_q <= {48'b0, rd_sh[15:0]};
              default: rd_q <= {32'b0, pci_rdata};
            endcase
            st <= S_RSP;
          end
        end
        S_ERR: begin rd_q <= '0; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && !pci_done |=> pci_valid && $stable(pci_addr) && $stable(pci_be_n) && $stable(pci_wdata) && $stable(pci_write));
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  assert_be_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid |-> ($countones(~pci_be_n) == 1 || $countones(~pci_be_n) == 2 || $countones(~pci_be_n) == 4));
  assert_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_done && !pci_valid && !$past(pci_valid));
  assert_quad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && pci_done && quad_q && !half_q |=> pci_valid &&
    pci_addr[LOW_W-1:0] == $past(pci_addr[LOW_W-1:0]) + LOW_W'(4));
endmodule

// File: tb/test_sparse_xlate.sv
module test_sparse_xlate;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_write = 0, cpu_quad = 0;
  logic [31:3] cpu_addr = '0;
  logic [63:0] cpu_wdata = '0;
  logic cpu_busy, cpu_done, cpu_err;
  logic [63:0] cpu_rdata;
  logic csr_we = 0;
  logic [2:0] csr_wdata = '0;
  logic pci_valid, pci_write;
  logic [31:0] pci_addr, pci_wdata;
  logic [3:0] pci_be_n;
  logic pci_done = 0;
  logic [31:0] pci_rdata = '0;

  int total = 0, bad = 0;
  logic [2:0] ext_m = 3'b000;

  sparse_xlate i_sparse_xlate (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [26:0] p, logic [1:0] len);
    return {p, len, 3'b000};
  endfunction

  function automatic logic [31:0] e_addr(logic [2:0] x, logic [26:0] p);
    return {x, 2'b00, p[26:2], 2'b00};
  endfunction

  function automatic logic [3:0] e_be(logic [1:0] len, logic [1:0] off);
    logic [3:0] b = 4'b1111;
    for (int i = 0; i < 4; i++) begin
      if (len == 2'b11) b[i] = 1'b0;
      else if (len == 2'b00 && i == off) b[i] = 1'b0;
      else if (len == 2'b01 && (i == off || i == off + 1)) b[i] = 1'b0;
    end
    return b;
  endfunction

  task automatic issue(logic wr, logic q, logic [31:0] a, logic [63:0] wd);
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_quad = q; cpu_addr = a[31:3]; cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 0;
  endtask

  task automatic serve(logic [31:0] rd);
    pci_done = 1; pci_rdata = rd;
    @(negedge clk);
    pci_done = 0;
  endtask

  task automatic set_ext(logic [2:0] v);
    @(negedge clk);
    csr_we = 1; csr_wdata = v;
    @(negedge clk);
    csr_we = 0; ext_m = v;
  endtask

  task automatic t_single(logic wr, logic [1:0] len, logic [26:0] p, logic [31:0] wd, logic [31:0] rd);
    logic [1:0] off = p[1:0];
    logic [31:0] ewd, erd, sh;
    ewd = (len == 2'b11) ? wd : wd << (8 * off);
    sh = rd >> (8 * off);
    erd = (len == 2'b00) ? {24'b0, sh[7:0]} : (len == 2'b01) ? {16'b0, sh[15:0]} : rd;
    issue(wr, 1'b0, mk(p, len), {32'hdead_beef, wd});
    chk("R8 pci_valid", pci_valid, 1);
    chk("R8 busy", cpu_busy, 1);
    chk("R1 pci_addr", pci_addr, e_addr(ext_m, p));
    chk("R2 pci_be_n", pci_be_n, e_be(len, off));
    chk("R8 pci_write", pci_write, wr);
    if (wr) chk("R3 pci_wdata", pci_wdata, ewd);
    serve(rd);
    chk("R8 cpu_done", cpu_done, 1);
    chk("R6 no err", cpu_err, 0);
    chk("R8 pci_valid drop", pci_valid, 0);
    if (!wr) chk("R4 cpu_rdata", cpu_rdata, {32'b0, erd});
    @(negedge clk);
    chk("R8 done pulse", cpu_done, 0);
  endtask

  task automatic t_reset;
    chk("R9 pci_valid", pci_valid, 0);
    chk("R9 cpu_busy", cpu_busy, 0);
    chk("R9 cpu_done", cpu_done, 0);
    chk("R9 cpu_err", cpu_err, 0);
    t_single(0, 2'b11, 27'h0123450, 32'h0, 32'h1234_5678);
  endtask

  task automatic t_bytes_words;
    set_ext(3'b101);
    for (int o = 0; o < 4; o++) begin
      t_single(1, 2'b00, 27'h4_5670 + 27'(o), 32'h0000_00a5 + 32'(o), 32'h0);
      t_single(0, 2'b00, 27'h1_2340 + 27'(o), 32'h0, 32'hc3d2_e1f0);
    end
    for (int o = 0; o < 3; o++) begin
      t_single(1, 2'b01, 27'h7ff_ff00 + 27'(o), 32'h0000_b00c, 32'h0);
      t_single(0, 2'b01, 27'h2a0 + 27'(o), 32'h0, 32'h8844_2211);
    end
    t_single(1, 2'b11, 27'h555_5554, 32'hfeed_f00d, 32'h0);
    t_single(0, 2'b11, 27'h0abc, 32'h0, 32'h9abc_def0);
  endtask

  task automatic t_quad(logic wr);
    logic [26:0] p = 27'h310_0a00;
    issue(wr, 1'b1, mk(p, 2'b11), 64'h1111_2222_3333_4444);
    chk("R5 q1 addr", pci_addr, e_addr(ext_m, p));
    chk("R5 q1 be", pci_be_n, 4'b0000);
    if (wr) chk("R5 q1 wdata", pci_wdata, 32'h3333_4444);
    serve(32'haaaa_0001);
    chk("R5 q2 valid", pci_valid, 1);
    chk("R5 q2 addr", pci_addr, e_addr(ext_m, p) + 32'd4);
    chk("R5 no early done", cpu_done, 0);
    if (wr) chk("R5 q2 wdata", pci_wdata, 32'h1111_2222);
    serve(32'hbbbb_0002);
    chk("R5 done", cpu_done, 1);
    if (!wr) chk("R5 rdata", cpu_rdata, 64'hbbbb_0002_aaaa_0001);
    @(negedge clk);
  endtask

  task automatic t_illegal(logic [1:0] len, logic [1:0] off);
    issue(0, 1'b0, mk({25'h12, off}, len), 64'h0);
    chk("R6 done", cpu_done, 1);
    chk("R6 err", cpu_err, 1);
    chk("R6 no pci", pci_valid, 0);
    @(negedge clk);
    chk("R6 clear", cpu_done, 0);
    chk("R6 still no pci", pci_valid, 0);
  endtask

  task automatic t_ext_inflight;
    logic [26:0] p = 27'h0c0_ffe0;
    logic [2:0] old = ext_m;
    issue(1, 1'b0, mk(p, 2'b11), 64'h5);
    set_ext(3'b010);
    chk("R7 inflight addr", pci_addr, e_addr(old, p));
    serve(32'h0);
    @(negedge clk);
    t_single(0, 2'b11, p, 32'h0, 32'h7777_0000);
  endtask

  task automatic t_busy_hold;
    logic [26:0] p = 27'h066_6664;
    issue(0, 1'b0, mk(p, 2'b00), 64'h0);
    repeat (3) @(negedge clk);
    chk("R8 hold valid", pci_valid, 1);
    chk("R8 hold addr", pci_addr, e_addr(ext_m, p));
    cpu_valid = 1; cpu_addr = mk(27'h111_1110, 2'b11) >> 3;
    @(negedge clk);
    cpu_valid = 0;
    chk("R8 ignore addr", pci_addr, e_addr(ext_m, p));
    chk("R8 ignore be", pci_be_n, e_be(2'b00, 2'b00));
    serve(32'h0000_00c4);
    chk("R4 hold rdata", cpu_rdata, 64'hc4);
    @(negedge clk);
    chk("R8 no extra req", pci_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bytes_words();
    t_quad(1);
    t_quad(0);
    t_illegal(2'b01, 2'b11);
    t_illegal(2'b10, 2'b00);
    t_ext_inflight();
    t_busy_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule